// File: doc/BRIEF.md
# Registered Bidirectional Pin Cell

This block sits between core logic and a group of tri-state pads. Each pad has its own lane. A lane holds three flip-flops: one captures the pad value, one holds data to be driven, and one holds the drive enable. Two mux selects are meant to be tied off when the block is placed. One chooses whether the pad gets the core's data directly or the registered copy. The other makes the same choice for the tri-state enable.

The core always sees two views of the pad at once: the live pad level and the value held in the capture register. When the pad is not driven, the data register can still be loaded and read back. That lets a pin that is never enabled act as plain registered feedback. All registers share one clock, one synchronous active-high reset and one synchronous set, with reset taking priority. Each kind of register has its own clock enable.

Top module: `pin_cell_array`

## Requirements
- R1: A cycle with `rst` high clears the capture, data and enable registers of every lane to 0 at the next clock edge.
- R2: A cycle with `set` high and `rst` low loads 1 into all three registers of every lane. When `rst` and `set` are both high, the registers are cleared.
- R3: When `ce_cap` is high at a clock edge without reset or set, `din_reg` takes the pad level. When `ce_cap` is low, `din_reg` keeps its value.
- R4: `din_comb` always shows the current pad level, in the same cycle that `din_reg` shows the captured value.
- R5: The data register loads `dout` only when `ce_dat` is high, and the enable register loads `oe` only when `ce_en` is high. Each enable affects only its own register.
- R6: With `sel_dat_reg` = 0 the pad data comes straight from `dout`. With `sel_dat_reg` = 1 it comes from the data register.
- R7: With `sel_en_reg` = 0 the tri-state enable comes straight from `oe`. With `sel_en_reg` = 1 it comes from the enable register. A 1 means drive.
- R8: When the selected enable of a lane is 0, the lane leaves its pad at high impedance. The external level then appears on `din_comb` and can be captured by the capture register.
- R9: `fb` shows the data register's contents whatever the enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all registers |
| rst | input | 1 | Synchronous reset, active high, wins over set |
| set | input | 1 | Synchronous set of all registers to 1 |
| ce_cap | input | 1 | Clock enable of the capture registers |
| ce_dat | input | 1 | Clock enable of the data registers |
| ce_en | input | 1 | Clock enable of the drive-enable registers |
| sel_dat_reg | input | 1 | Static select: 1 = registered pad data |
| sel_en_reg | input | 1 | Static select: 1 = registered drive enable |
| dout | input | LANES | Data from the core to the pads |
| oe | input | LANES | Drive enable from the core, 1 = drive |
| pad | inout | LANES | Tri-state pads |
| din_comb | output | LANES | Live pad level |
| din_reg | output | LANES | Captured pad level |
| fb | output | LANES | Data register contents |

## Verification
The pad, `din_comb` and the combinational mux paths respond within the same cycle as their inputs. The bench therefore compares them at the falling edge that follows each input change, and it drives the external side of the pad only on lanes its own model expects to be released. `din_reg` and `fb` move one rising edge after an enabled load, reset or set. The behavioural model updates its register copies at that edge, and the comparison happens at the falling edge after it, so that no register is checked early. Reset-against-set priority and the state right after reset are also checked once each at the falling edge after the deciding clock.

// File: rtl/pin_cell_pkg.sv
package pin_cell_pkg;
  typedef enum logic [1:0] {
    CTL_LOAD  = 2'd0,
    CTL_HOLD  = 2'd1,
    CTL_SET   = 2'd2,
    CTL_CLEAR = 2'd3
  } reg_ctl_e;

  function automatic reg_ctl_e decode_ctl(input logic rst, input logic set, input logic ce);
    if (rst)      return CTL_CLEAR;
    else if (set) return CTL_SET;
    else if (ce)  return CTL_LOAD;
    else          return CTL_HOLD;
  endfunction
endpackage

// File: rtl/pin_cell_ff.sv
module pin_cell_ff
  import pin_cell_pkg::*;
#(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  reg_ctl_e ctl;
  assign ctl = decode_ctl(rst, set, ce);

  always_ff @(posedge clk) begin
    case (ctl)
      CTL_CLEAR: q <= '0;
      CTL_SET:   q <= '1;
      CTL_LOAD:  q <= d;
      default:   q <= q;
    endcase
  end

  // R1
  ff_clear_chk: assert property (@(posedge clk) $past(rst) |-> q == '0);
  // R2
  ff_set_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(set) && !$past(rst)) |-> q == '1);
endmodule

// File: rtl/pin_cell_lane.sv
module pin_cell_lane (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic ce_cap,
  input  logic ce_dat,
  input  logic ce_en,
  input  logic sel_dat_reg,
  input  logic sel_en_reg,
  input  logic dout,
  input  logic oe,
  inout  wire  pad,
  output logic din_comb,
  output logic din_reg,
  output logic fb
);
  logic cap_q, dat_q, en_q;
  logic drv_data, drv_en, pad_lvl;

  assign pad_lvl = pad;

  pin_cell_ff #(.W(1)) u_cap (.clk(clk), .rst(rst), .set(set), .ce(ce_cap), .d(pad_lvl), .q(cap_q));
  pin_cell_ff #(.W(1)) u_dat (.clk(clk), .rst(rst), .set(set), .ce(ce_dat), .d(dout),    .q(dat_q));
  pin_cell_ff #(.W(1)) u_en  (.clk(clk), .rst(rst), .set(set), .ce(ce_en),  .d(oe),      .q(en_q));

  assign drv_data = sel_dat_reg ? dat_q : dout;
  assign drv_en   = sel_en_reg  ? en_q  : oe;
  assign pad      = drv_en ? drv_data : 1'bz;

  assign din_comb = pad_lvl;
  assign din_reg  = cap_q;
  assign fb       = dat_q;

  // R3
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(ce_cap) && !$past(rst) && !$past(set)) |-> $stable(din_reg));
  // R3
  cap_load_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ce_cap) && !$past(rst) && !$past(set)) |-> din_reg == $past(din_comb));
  // R5
  dat_load_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ce_dat) && !$past(rst) && !$past(set)) |-> fb == $past(dout));
  // R9
  dat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(ce_dat) && !$past(rst) && !$past(set)) |-> $stable(fb));
endmodule

// File: rtl/pin_cell_array.sv
module pin_cell_array #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set,
  input  logic             ce_cap,
  input  logic             ce_dat,
  input  logic             ce_en,
  input  logic             sel_dat_reg,
  input  logic             sel_en_reg,
  input  logic [LANES-1:0] dout,
  input  logic [LANES-1:0] oe,
  inout  wire  [LANES-1:0] pad,
  output logic [LANES-1:0] din_comb,
  output logic [LANES-1:0] din_reg,
  output logic [LANES-1:0] fb
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pin_cell_lane u_lane (
      .clk(clk), .rst(rst), .set(set),
      .ce_cap(ce_cap), .ce_dat(ce_dat), .ce_en(ce_en),
      .sel_dat_reg(sel_dat_reg), .sel_en_reg(sel_en_reg),
      .dout(dout[i]), .oe(oe[i]), .pad(pad[i]),
      .din_comb(din_comb[i]), .din_reg(din_reg[i]), .fb(fb[i])
    );
  end
endmodule

// File: tb/pin_cell_array_tb.sv
module pin_cell_array_tb;
  localparam int L = 4;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, set, ce_cap, ce_dat, ce_en, sel_dat_reg, sel_en_reg;
  logic [L-1:0] dout, oe, ext, din_comb, din_reg, fb;
  wire  [L-1:0] pad;

  int tests = 0, fails = 0;

  // behavioural reference registers
  logic [L-1:0] m_cap = '0, m_dat = '0, m_en = '0;
  logic [L-1:0] e_en, e_data, e_pad;
  always_comb begin
    e_en   = sel_en_reg  ? m_en  : oe;
    e_data = sel_dat_reg ? m_dat : dout;
    for (int i = 0; i < L; i++) e_pad[i] = e_en[i] ? e_data[i] : ext[i];
  end

  // external driver only where the model expects release (R8)
  for (genvar i = 0; i < L; i++) begin : g_ext
    assign pad[i] = e_en[i] ? 1'bz : ext[i];
  end

  always @(posedge clk) begin
    if (rst) begin
      m_cap <= '0; m_dat <= '0; m_en <= '0;
    end else if (set) begin
      m_cap <= '1; m_dat <= '1; m_en <= '1;
    end else begin
      if (ce_cap) m_cap <= e_pad;
      if (ce_dat) m_dat <= dout;
      if (ce_en)  m_en  <= oe;
    end
  end

  pin_cell_array #(.LANES(L)) u_dut (
    .clk(clk), .rst(rst), .set(set), .ce_cap(ce_cap), .ce_dat(ce_dat), .ce_en(ce_en),
    .sel_dat_reg(sel_dat_reg), .sel_en_reg(sel_en_reg), .dout(dout), .oe(oe),
    .pad(pad), .din_comb(din_comb), .din_reg(din_reg), .fb(fb)
  );

  task automatic chk(input string tag, input logic [L-1:0] act, input logic [L-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R6 R7 R8 pad", pad, e_pad);
    chk("R4 din_comb", din_comb, e_pad);
    chk("R3 din_reg", din_reg, m_cap);
    chk("R5 R9 fb", fb, m_dat);
  endtask

  task automatic rand_inputs();
    dout = L'($urandom); oe = L'($urandom); ext = L'($urandom);
    ce_cap = 1'($urandom); ce_dat = 1'($urandom); ce_en = 1'($urandom);
  endtask

  initial begin
    rst = 1'b1; set = 1'b0; ce_cap = 1'b1; ce_dat = 1'b1; ce_en = 1'b1;
    sel_dat_reg = 1'b1; sel_en_reg = 1'b1; dout = '1; oe = '1; ext = '1;
    @(posedge clk); @(negedge clk);
    // R1: all registers clear, pad released with registered enable
    chk("R1 din_reg", din_reg, '0);
    chk("R1 fb", fb, '0);
    chk("R1 pad released", pad, ext);
    // R2: reset wins over set
    set = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2 rst over set fb", fb, '0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R2 set fb", fb, '1);
    chk("R2 set din_reg", din_reg, '1);
    set = 1'b0;
    // random phases over every mux combination (R3..R9)
    for (int mode = 0; mode < 4; mode++) begin
      sel_dat_reg = mode[0]; sel_en_reg = mode[1];
      for (int c = 0; c < 200; c++) begin
        rand_inputs();
        if (c % 50 == 49) set = 1'b1; else set = 1'b0;
        if (c % 70 == 69) rst = 1'b1; else rst = 1'b0;
        #1 compare_all();
        @(posedge clk); @(negedge clk);
        compare_all();
      end
    end
    // R9: enable off permanently, data register still visible as feedback
    sel_en_reg = 1'b0; oe = '0; set = 1'b0; rst = 1'b0;
    for (int c = 0; c < 20; c++) begin
      dout = L'($urandom); ext = L'($urandom); ce_dat = 1'b1; ce_cap = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R9 fb disabled", fb, m_dat);
      chk("R8 ext seen", din_comb, ext);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule